// File: doc/BRIEF.md
# Exception Priority Mask Gate

This block decides, for one exception request at a time, whether that request may activate. It looks at the exception number and the request's configurable priority value, and combines three mask registers: a one-bit primary mask, a one-bit fault mask and a base priority threshold. It also holds those three registers. Software-side logic writes and reads them through a plain register port, and the exception sequencer reports handler exits through an exit strobe, which can clear the fault mask on its own.

The decision path is purely combinational, from the request pins and the mask state to `allow`. An arbiter placed in front of the gate can therefore test a candidate in the same cycle it picks it. Lower numeric priority values are more urgent. Only the upper `PRIO_BITS` bits of any 8-bit priority field are implemented. Both the stored threshold and the incoming request priority are truncated to those bits before they are compared. No port of the block carries a stream, so there is no valid/ready handshake and no back-pressure. Every pin is plain control or status, sampled either at the clock edge (writes and exit) or continuously (requests and reads).

The exception numbers are fixed as follows: 2 is the non-maskable interrupt, 3 is hard fault, and 4, 5, 6, 11, 14 and 15 are the configurable system exceptions. 16+k is external interrupt k, for k from 0 to `NUM_IRQ`-1. `PRIO_BITS` may range from 3 to 8.

Top module: `excmask_gate`

## Requirements
- R1: After reset, reads of the primary mask, the fault mask and the base threshold all return 0.
- R2: A write with `wr_sel`=0 loads bit 0 of `wr_data` into the primary mask, `wr_sel`=1 loads bit 0 into the fault mask, and `wr_sel`=2 loads the base threshold. Each one-bit mask reads back as 7 zero bits above its value. A write with `wr_sel`=3 changes nothing, and a read with `rd_sel`=3 returns 0.
- R3: The low 8-`PRIO_BITS` bits of the base threshold always read as 0, and any value written to them is discarded.
- R4: While the primary mask is 1, every configurable exception (4, 5, 6, 11, 14, 15 and every implemented external interrupt) is refused. The primary mask has no effect on numbers 2 and 3.
- R5: While the fault mask is 1, every exception except number 2 is refused, and that includes hard fault.
- R6: A base threshold of 0 has no effect. A nonzero threshold refuses every configurable exception whose truncated priority is greater than or equal to the threshold, and allows those whose truncated priority is below it.
- R7: The low 8-`PRIO_BITS` bits of `req_prio` are ignored in the threshold comparison.
- R8: Number 2 is always allowed. Number 3 is allowed unless the fault mask is 1. `req_prio` has no effect on either of them.
- R9: Numbers 0, 1, 7 to 10, 12, 13, and every number at or above 16+`NUM_IRQ` are never allowed.
- R10: An exit strobe carrying any number other than 2 clears the fault mask at that clock edge. An exit carrying 2 leaves the fault mask unchanged.
- R11: When a fault-mask write and a clearing exit fall on the same edge, the written value is kept.
- R12: `allow` and `rd_data` follow their inputs within the same cycle, and a register write becomes visible right after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 primary, 1 fault, 2 base, 3 none |
| wr_data | input | 8 | Write value |
| rd_sel | input | 2 | Read target, same coding as wr_sel |
| rd_data | output | 8 | Read value |
| exit_valid | input | 1 | A handler is being left this cycle |
| exit_num | input | 9 | Exception number of the handler being left |
| req_num | input | 9 | Exception number of the candidate request |
| req_prio | input | 8 | Configurable priority of the candidate request |
| allow | output | 1 | The candidate may activate |

## Verification
The bench builds the gate with `PRIO_BITS`=3 and `NUM_IRQ`=4. With three implemented bits, both the discarded low bits of the threshold and the discarded low bits of the request priority are exposed, so a request that differs from the threshold only in ignored bits lands exactly on the equal-priority boundary. With four interrupts the first unimplemented interrupt number (20) sits right next to the last valid one (19), which makes the upper edge of the number range directly testable.

// File: rtl/excmask_pkg.sv
package excmask_pkg;
  localparam int NUM_W = 9;
  localparam int PRIO_W = 8;
  localparam logic [NUM_W-1:0] NMI_NUM = 9'd2;
  localparam logic [NUM_W-1:0] HARD_NUM = 9'd3;
  localparam logic [NUM_W-1:0] IRQ_BASE = 9'd16;

  typedef enum logic [1:0] {
    SEL_PRIMARY = 2'd0,
    SEL_FAULT   = 2'd1,
    SEL_BASE    = 2'd2,
    SEL_NONE    = 2'd3
  } mask_sel_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_NMI  = 2'd1,
    KIND_HARD = 2'd2,
    KIND_CFG  = 2'd3
  } exc_kind_e;

  // Keep-mask for an 8-bit priority field with 'bits' implemented MSBs
  function automatic logic [PRIO_W-1:0] prio_keep(input int bits);
    logic [PRIO_W-1:0] m;
    for (int i = 0; i < PRIO_W; i++) begin
      m[i] = (i >= PRIO_W - bits);
    end
    return m;
  endfunction
endpackage

// File: rtl/excmask_regs.sv
module excmask_regs
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PRIO_W-1:0] wr_data,
  input  logic              exit_valid,
  input  logic [NUM_W-1:0]  exit_num,
  input  logic [1:0]        rd_sel,
  output logic [PRIO_W-1:0] rd_data,
  output logic              pm_o,
  output logic              fm_o,
  output logic [PRIO_W-1:0] bp_o
);
  localparam logic [PRIO_W-1:0] KEEP = prio_keep(PRIO_BITS);

  logic              pm_q;
  logic              fm_q;
  logic [PRIO_W-1:0] bp_q;
  logic              wr_pm;
  logic              wr_fm;
  logic              wr_bp;
  logic              exit_clr;

  assign wr_pm    = wr_en && (mask_sel_e'(wr_sel) == SEL_PRIMARY);
  assign wr_fm    = wr_en && (mask_sel_e'(wr_sel) == SEL_FAULT);
  assign wr_bp    = wr_en && (mask_sel_e'(wr_sel) == SEL_BASE);
  assign exit_clr = exit_valid && (exit_num != NMI_NUM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q <= 1'b0;
      fm_q <= 1'b0;
      bp_q <= '0;
    end else begin
      if (wr_pm) pm_q <= wr_data[0];
      // a same-edge write outranks the exit clear
      if (wr_fm)         fm_q <= wr_data[0];
      else if (exit_clr) fm_q <= 1'b0;
      if (wr_bp) bp_q <= wr_data & KEEP;
    end
  end

  always_comb begin
    unique case (mask_sel_e'(rd_sel))
      SEL_PRIMARY: rd_data = {{(PRIO_W-1){1'b0}}, pm_q};
      SEL_FAULT:   rd_data = {{(PRIO_W-1){1'b0}}, fm_q};
      SEL_BASE:    rd_data = bp_q;
      default:     rd_data = '0;
    endcase
  end

  assign pm_o = pm_q;
  assign fm_o = fm_q;
  assign bp_o = bp_q;
endmodule

// File: rtl/excmask_classify.sv
module excmask_classify
  import excmask_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_W-1:0] req_num,
  output exc_kind_e        kind
);
  localparam logic [NUM_W:0] IRQ_END = NUM_W'(IRQ_BASE) + (NUM_W+1)'(NUM_IRQ);
  localparam int NSYS = 6;
  localparam logic [NUM_W-1:0] SYS_CFG [NSYS] = '{9'd4, 9'd5, 9'd6, 9'd11, 9'd14, 9'd15};

  logic [NSYS-1:0] sys_hit;
  logic            irq_hit;

  for (genvar g = 0; g < NSYS; g++) begin : g_sys
    assign sys_hit[g] = (req_num == SYS_CFG[g]);
  end

  assign irq_hit = (req_num >= IRQ_BASE) && ({1'b0, req_num} < IRQ_END);

  always_comb begin
    if (req_num == NMI_NUM)        kind = KIND_NMI;
    else if (req_num == HARD_NUM)  kind = KIND_HARD;
    else if (|sys_hit || irq_hit)  kind = KIND_CFG;
    else                           kind = KIND_NONE;
  end
endmodule

// File: rtl/excmask_decide.sv
module excmask_decide
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 8
) (
  input  exc_kind_e         kind,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              pm,
  input  logic              fm,
  input  logic [PRIO_W-1:0] bp,
  output logic              allow
);
  localparam logic [PRIO_W-1:0] KEEP = prio_keep(PRIO_BITS);

  logic [PRIO_W-1:0] eff_prio;
  logic              base_block;

  assign eff_prio   = req_prio & KEEP;
  assign base_block = (bp != '0) && (eff_prio >= bp);

  always_comb begin
    unique case (kind)
      KIND_NMI:  allow = 1'b1;
      KIND_HARD: allow = !fm;
      KIND_CFG:  allow = !(pm || fm || base_block);
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/excmask_gate.sv
module excmask_gate
  import excmask_pkg::*;
#(
  parameter int PRIO_BITS = 8,
  parameter int NUM_IRQ   = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       exit_valid,
  input  logic [8:0] exit_num,
  input  logic [8:0] req_num,
  input  logic [7:0] req_prio,
  output logic       allow
);
  logic              pm_w;
  logic              fm_w;
  logic [PRIO_W-1:0] bp_w;
  exc_kind_e         kind_w;

  excmask_regs #(.PRIO_BITS(PRIO_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .exit_valid(exit_valid), .exit_num(exit_num),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .pm_o(pm_w), .fm_o(fm_w), .bp_o(bp_w)
  );

  excmask_classify #(.NUM_IRQ(NUM_IRQ)) u_class (
    .req_num(req_num), .kind(kind_w)
  );

  excmask_decide #(.PRIO_BITS(PRIO_BITS)) u_decide (
    .kind(kind_w), .req_prio(req_prio),
    .pm(pm_w), .fm(fm_w), .bp(bp_w),
    .allow(allow)
  );
endmodule

// File: rtl/excmask_gate_chk.sv
module excmask_gate_chk #(
  parameter int PRIO_BITS = 8,
  parameter int NUM_IRQ   = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       exit_valid,
  input logic [8:0] exit_num,
  input logic [8:0] req_num,
  input logic [7:0] req_prio,
  input logic       allow,
  input logic       pm,
  input logic       fm,
  input logic [7:0] bp
);
  localparam logic [7:0] LOWBITS = 8'((1 << (8 - PRIO_BITS)) - 1);

  logic cfg_req;
  assign cfg_req = (req_num == 9'd4) || (req_num == 9'd5) || (req_num == 9'd6) ||
                   (req_num == 9'd11) || (req_num == 9'd14) || (req_num == 9'd15) ||
                   ((req_num >= 9'd16) && (int'(req_num) < 16 + NUM_IRQ));

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (!pm && !fm && bp == 8'd0));

  assert_base_lowbits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bp & LOWBITS) == 8'd0);

  assert_primary_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pm && cfg_req) |-> !allow);

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fm && req_num != 9'd2) |-> !allow);

  assert_base_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && bp != 8'd0 && ({req_prio[7:1], 1'b0} >= {bp[7:1], 1'b1})) |-> !allow);

  assert_nmi_allowed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_num == 9'd2) |-> allow);

  assert_unknown_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_num != 9'd2 && req_num != 9'd3 && !cfg_req) |-> !allow);

  assert_exit_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_valid && exit_num != 9'd2 && !(wr_en && wr_sel == 2'd1)) |=> !fm);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> (fm == $past(wr_data[0])));
endmodule

bind excmask_gate excmask_gate_chk #(.PRIO_BITS(PRIO_BITS), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .exit_valid(exit_valid), .exit_num(exit_num), .req_num(req_num),
  .req_prio(req_prio), .allow(allow), .pm(pm_w), .fm(fm_w), .bp(bp_w)
);

// File: tb/sim_excmask_gate.sv
`timescale 1ns/1ps
module sim_excmask_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       exit_valid = 1'b0;
  logic [8:0] exit_num = 9'd0;
  logic [8:0] req_num = 9'd0;
  logic [7:0] req_prio = 8'd0;
  logic       allow;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  excmask_gate #(.PRIO_BITS(3), .NUM_IRQ(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .exit_valid(exit_valid), .exit_num(exit_num),
    .req_num(req_num), .req_prio(req_prio), .allow(allow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] sel, input logic [7:0] exp);
    rd_sel = sel; #1;
    check(req, rd_data, exp);
  endtask

  task automatic ask(input string req, input int num, input logic [7:0] prio, input logic exp);
    req_num = 9'(num); req_prio = prio; #1;
    check(req, {7'd0, allow}, {7'd0, exp});
  endtask

  task automatic clear_all();
    wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
  endtask

  task automatic t_reset();
    rd_check("R1 primary", 2'd0, 8'h00);
    rd_check("R1 fault", 2'd1, 8'h00);
    rd_check("R1 base", 2'd2, 8'h00);
  endtask

  task automatic t_regs();
    wr(2'd0, 8'hFF); rd_check("R2 primary set", 2'd0, 8'h01);
    wr(2'd0, 8'hFE); rd_check("R2 primary bit0 only", 2'd0, 8'h00);
    wr(2'd1, 8'h03); rd_check("R2 fault set", 2'd1, 8'h01);
    wr(2'd2, 8'h80);
    wr(2'd3, 8'hFF);
    rd_check("R2 sel3 leaves fault", 2'd1, 8'h01);
    rd_check("R2 sel3 leaves primary", 2'd0, 8'h00);
    rd_check("R2 sel3 leaves base", 2'd2, 8'h80);
    rd_check("R2 sel3 reads zero", 2'd3, 8'h00);
    clear_all();
  endtask

  task automatic t_base_trunc();
    wr(2'd2, 8'h5F); rd_check("R3 low bits dropped", 2'd2, 8'h40);
    wr(2'd2, 8'h1F); rd_check("R3 all-low write reads zero", 2'd2, 8'h00);
    ask("R3 truncated zero threshold has no effect", 16, 8'hE0, 1'b1);
    clear_all();
  endtask

  task automatic t_primary();
    wr(2'd0, 8'h01);
    ask("R4 irq16", 16, 8'h00, 1'b0);
    ask("R4 irq19", 19, 8'h00, 1'b0);
    ask("R4 svc 11", 11, 8'h00, 1'b0);
    ask("R4 num 4", 4, 8'h00, 1'b0);
    ask("R4 num 15", 15, 8'h00, 1'b0);
    ask("R4 hard fault passes", 3, 8'h00, 1'b1);
    ask("R4 nmi passes", 2, 8'h00, 1'b1);
    clear_all();
  endtask

  task automatic t_fault();
    wr(2'd1, 8'h01);
    ask("R5 hard fault blocked", 3, 8'h00, 1'b0);
    ask("R5 irq blocked", 17, 8'h00, 1'b0);
    ask("R5 num 6 blocked", 6, 8'h00, 1'b0);
    ask("R5 nmi passes", 2, 8'hFF, 1'b1);
    clear_all();
  endtask

  task automatic t_base();
    ask("R6 zero threshold", 16, 8'hE0, 1'b1);
    wr(2'd2, 8'h80);
    ask("R6 below threshold", 16, 8'h60, 1'b1);
    ask("R6 equal threshold", 16, 8'h80, 1'b0);
    ask("R6 above threshold", 14, 8'hA0, 1'b0);
    ask("R6 svc below", 11, 8'h60, 1'b1);
    ask("R6 hard fault unaffected", 3, 8'hFF, 1'b1);
    clear_all();
  endtask

  task automatic t_prio_mask();
    wr(2'd2, 8'h40);
    ask("R7 low bits ignored below", 16, 8'h3F, 1'b1);
    ask("R7 low bits ignored equal", 16, 8'h5F, 1'b0);
    ask("R7 plain below", 16, 8'h20, 1'b1);
    clear_all();
  endtask

  task automatic t_fixed();
    wr(2'd0, 8'h01); wr(2'd2, 8'h20);
    ask("R8 hard fault fixed", 3, 8'hFF, 1'b1);
    ask("R8 nmi fixed", 2, 8'hFF, 1'b1);
    clear_all();
  endtask

  task automatic t_invalid();
    ask("R9 num 0", 0, 8'h00, 1'b0);
    ask("R9 num 1", 1, 8'h00, 1'b0);
    ask("R9 num 7", 7, 8'h00, 1'b0);
    ask("R9 num 10", 10, 8'h00, 1'b0);
    ask("R9 num 12", 12, 8'h00, 1'b0);
    ask("R9 num 13", 13, 8'h00, 1'b0);
    ask("R9 first unimplemented irq", 20, 8'h00, 1'b0);
    ask("R9 num 300", 300, 8'h00, 1'b0);
    ask("R9 last irq valid", 19, 8'h00, 1'b1);
    ask("R9 num 15 valid", 15, 8'h00, 1'b1);
  endtask

  task automatic exit_pulse(input int num);
    @(negedge clk);
    exit_valid = 1'b1; exit_num = 9'(num);
    @(negedge clk);
    exit_valid = 1'b0;
  endtask

  task automatic t_exit();
    wr(2'd1, 8'h01);
    exit_pulse(2);
    rd_check("R10 nmi exit keeps fault mask", 2'd1, 8'h01);
    exit_pulse(16);
    rd_check("R10 irq exit clears fault mask", 2'd1, 8'h00);
    wr(2'd1, 8'h01);
    exit_pulse(3);
    rd_check("R10 hard fault exit clears", 2'd1, 8'h00);
    clear_all();
  endtask

  task automatic t_exit_write();
    @(negedge clk);
    exit_valid = 1'b1; exit_num = 9'd5;
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h01;
    @(negedge clk);
    exit_valid = 1'b0; wr_en = 1'b0;
    rd_check("R11 write outranks exit", 2'd1, 8'h01);
    clear_all();
  endtask

  task automatic t_comb();
    wr(2'd2, 8'h60);
    @(negedge clk);
    ask("R12 same-cycle allow", 16, 8'h40, 1'b1);
    ask("R12 same-cycle refuse", 16, 8'h60, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'hA0;
    rd_sel = 2'd2; #1;
    check("R12 no update before edge", rd_data, 8'h60);
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R12 visible after edge", rd_data, 8'hA0);
    clear_all();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_base_trunc();
    t_primary();
    t_fault();
    t_base();
    t_prio_mask();
    t_fixed();
    t_invalid();
    t_exit();
    t_exit_write();
    t_comb();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule